// File: doc/BRIEF.md
# Interleaved Sector Stream Sequencer

This block produces the byte stream a host sees while it reads one track of an emulated floppy. The track has a fixed number of sectors. They are not sent in numeric order. The block walks a 2:1 interleave instead: even slots carry the lower half of the sector numbers and odd slots carry the upper half, so a twelve-sector track goes 0,6,1,7,2,8,3,9,4,10,5,11 and then starts over. Each sector is sent as a run of sync bytes, then three address-mark bytes, then three identity bytes (track, sector, side), then the payload. The payload bytes are pulled from an external buffer one at a time. Encoding of the payload and checksums are done elsewhere.

One byte leaves the block every `BYTE_CLKS` clocks as a single-cycle strobe. At the first sync byte of each sector, the block names the sector it is about to send, so the buffer can fetch that sector's data. When the backing store is busy, for example while it commits a written sector, the host must see only filler. The block handles this by lengthening the sync run in front of the next address mark. A sector that has already started is always sent to the end. The host reads the longer gap as a slow inter-sector gap. A real drive sends a sector about every 12 ms, and the host gives up if a gap goes beyond roughly 23 ms. The store's busy time therefore has to stay inside that margin.

A change on the track or side inputs drops the sector in progress. The block then starts again at the first entry of the interleave order, using the new track and side values.

Top module: `sector_stream_seq`

## Requirements
- R1: While `rst_n` is low, `byte_vld`, `sec_req` and `pay_take` are 0. The first sector sent after reset is sector 0.
- R2: `byte_vld` is a one-cycle pulse. Consecutive pulses are exactly `BYTE_CLKS` clock cycles apart.
- R3: Sectors are started in the order 0,6,1,7,2,8,3,9,4,10,5,11 (for 12 sectors: slot i carries i/2 when i is even, and i/2 + SECTORS/2 when i is odd). After the last slot the order wraps back to sector 0.
- R4: Every sector begins with at least `SYNC_MIN` sync bytes, each of value 0xFF with `byte_is_sync` = 1. When `busy` is low at the end of the run, there are exactly `SYNC_MIN` of them.
- R5: The sync run is followed directly by the marks 0xD5, 0xAA, 0x96. Then come the track number, the sector number and the side, each zero-extended to 8 bits.
- R6: After the identity bytes, `PAY_BYTES` payload bytes are sent. `pay_take` is high for one cycle per payload byte. The byte appears with `byte_vld` on the following cycle and carries the `pay_data` value present while `pay_take` was high.
- R7: If `busy` is high when a byte strobe falls on the last sync byte of the minimum run, or on any later filler byte, the block keeps sending sync bytes. The marks start after the first filler byte that is sent while `busy` is low.
- R8: `busy` has no effect while marks, identity bytes or payload are being sent. The sector finishes unchanged, and no sync byte is inserted into it.
- R9: A change of `track` or `side` restarts the sequence. The next sector begun is sector 0, and its identity bytes carry the new track and side.
- R10: `sec_req` pulses together with the first sync byte of each sector (`byte_vld` and `byte_is_sync` are also high), and `sec_num` holds that sector's number.
- R11: `byte_is_sync` is high only on sync bytes. It is never high on a mark, identity or payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track | input | TRK_W | Current track number of the emulated head |
| side | input | 1 | Current head side |
| busy | input | 1 | Backing store busy; stretches the next inter-sector gap |
| pay_data | input | 8 | Next payload byte from the sector buffer |
| pay_take | output | 1 | Consumes `pay_data` in this cycle |
| sec_req | output | 1 | Start-of-sector pulse for the buffer |
| sec_num | output | 8 | Sector number announced by `sec_req` |
| byte_vld | output | 1 | Output byte strobe |
| byte_val | output | 8 | Output byte |
| byte_is_sync | output | 1 | Marks the byte as a 10-bit sync filler |

## Verification
The bound checker checks the following on every cycle:
- the byte strobe is a single-cycle pulse;
- each `pay_take` produces a non-sync byte on the next cycle;
- sync flags only ever sit on 0xFF strobes;
- a sector request always arrives on a sync byte and names an existing sector;
- the first byte after a sync run is always 0xD5, and is preceded by at least `SYNC_MIN` sync bytes.

Other behaviours can only be shown by the bench's scenarios:
- the exact interleave order and its wrap;
- the exact length of a stretched gap;
- that `busy` during a sector body leaves the sector intact;
- that payload bytes arrive in order;
- the restart to sector 0 after a track or side change.

// File: rtl/sss_pkg.sv
package sss_pkg;

    typedef enum logic [2:0] {
        ST_SYNC,   // minimum sync run before the marks
        ST_HOLD,   // stretched gap while the store is busy
        ST_MARK,   // three address-mark bytes
        ST_IDF,    // track, sector, side
        ST_DATA    // payload bytes from the buffer
    } seq_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    function automatic logic [7:0] mark_byte(input logic [1:0] pos);
        logic [7:0] b;
        unique case (pos)
            2'd0:    b = 8'hD5;
            2'd1:    b = 8'hAA;
            default: b = 8'h96;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sss_byte_pacer.sv
module sss_byte_pacer #(
    parameter int BYTE_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (BYTE_CLKS > 2) ? $clog2(BYTE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/sss_index_ctr.sv
module sss_index_ctr #(
    parameter int SECTORS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart,
    input  logic                       advance,
    output logic [$clog2(SECTORS)-1:0] idx
);
    localparam int IDX_W = $clog2(SECTORS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SECTORS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/sss_order_map.sv
module sss_order_map #(
    parameter int SECTORS    = 12,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic [$clog2(SECTORS)-1:0] idx,
    output logic [$clog2(SECTORS)-1:0] sec
);
    localparam int IDX_W = $clog2(SECTORS);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(SECTORS / 2);

    generate
        if (INTERLEAVE) begin : g_two_to_one
            always_comb begin
                sec = idx >> 1;
                if (idx[0]) begin
                    sec = (idx >> 1) + HALF;
                end
            end
        end else begin : g_linear
            assign sec = idx;
        end
    endgenerate
endmodule

// File: rtl/sector_stream_seq.sv
module sector_stream_seq
    import sss_pkg::*;
#(
    parameter int SECTORS    = 12,
    parameter int SYNC_MIN   = 5,
    parameter int PAY_BYTES  = 512,
    parameter int BYTE_CLKS  = 8,
    parameter int TRK_W      = 7,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRK_W-1:0] track,
    input  logic             side,
    input  logic             busy,
    input  logic [7:0]       pay_data,
    output logic             pay_take,
    output logic             sec_req,
    output logic [7:0]       sec_num,
    output logic             byte_vld,
    output logic [7:0]       byte_val,
    output logic             byte_is_sync
);
    localparam int IDX_W = $clog2(SECTORS);
    localparam int CNT_W = $clog2(PAY_BYTES + SYNC_MIN + 4);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_MIN - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(PAY_BYTES - 1);
    localparam logic [CNT_W-1:0] TRIO_LAST = CNT_W'(2);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TRK_W-1:0] trk_q;
    logic             side_q;
    logic             tick;
    logic             changed;
    logic             advance;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sec;
    logic [7:0]       byte_d;
    logic             in_gap;

    assign changed = (track != trk_q) || (side != side_q);
    assign advance = tick && !changed && (state_q == ST_DATA) && (cnt_q == DATA_LAST);
    assign in_gap  = (state_q == ST_SYNC) || (state_q == ST_HOLD);

    sss_byte_pacer #(.BYTE_CLKS(BYTE_CLKS)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sss_index_ctr #(.SECTORS(SECTORS)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (changed),
        .advance (advance),
        .idx     (idx)
    );

    sss_order_map #(.SECTORS(SECTORS), .INTERLEAVE(INTERLEAVE)) u_order (
        .idx (idx),
        .sec (sec)
    );

    // Transitions, taken only on a byte tick.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SYNC: begin
                if (cnt_q == SYNC_LAST) begin
                    cnt_d   = '0;
                    state_d = busy ? ST_HOLD : ST_MARK;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!busy) begin
                    cnt_d   = '0;
                    state_d = ST_MARK;
                end
            end
            ST_MARK: begin
                if (cnt_q == TRIO_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_IDF;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_IDF: begin
                if (cnt_q == TRIO_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_DATA;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_SYNC;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_SYNC;
            end
        endcase
    end

    // State register. A track or side change wins over the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            cnt_q   <= '0;
            trk_q   <= '0;
            side_q  <= 1'b0;
        end else if (changed) begin
            state_q <= ST_SYNC;
            cnt_q   <= '0;
            trk_q   <= track;
            side_q  <= side;
        end else if (tick) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Byte selected by the present state.
    always_comb begin
        byte_d = SYNC_BYTE;
        unique case (state_q)
            ST_SYNC, ST_HOLD: byte_d = SYNC_BYTE;
            ST_MARK:          byte_d = mark_byte(cnt_q[1:0]);
            ST_IDF: begin
                if (cnt_q == '0) begin
                    byte_d = 8'(trk_q);
                end else if (cnt_q == CNT_W'(1)) begin
                    byte_d = 8'(sec);
                end else begin
                    byte_d = 8'(side_q);
                end
            end
            ST_DATA:          byte_d = pay_data;
            default:          byte_d = SYNC_BYTE;
        endcase
    end

    assign pay_take = tick && (state_q == ST_DATA);

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld     <= 1'b0;
            byte_val     <= 8'h00;
            byte_is_sync <= 1'b0;
            sec_req      <= 1'b0;
            sec_num      <= 8'h00;
        end else begin
            byte_vld     <= tick;
            byte_is_sync <= tick && in_gap;
            sec_req      <= tick && (state_q == ST_SYNC) && (cnt_q == '0);
            if (tick) begin
                byte_val <= byte_d;
                sec_num  <= 8'(sec);
            end
        end
    end
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
    parameter int SYNC_MIN = 5,
    parameter int SECTORS  = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic [7:0] byte_val,
    input logic       byte_is_sync,
    input logic       sec_req,
    input logic [7:0] sec_num,
    input logic       pay_take
);
    logic       prev_sync;
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sync <= 1'b0;
            run       <= 8'h00;
        end else if (byte_vld) begin
            prev_sync <= byte_is_sync;
            if (!byte_is_sync) begin
                run <= 8'h00;
            end else if (run != 8'hFF) begin
                run <= run + 8'h01;
            end
        end
    end

    assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    assert_req_on_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |-> (byte_vld && byte_is_sync));

    assert_sector_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |-> (sec_num < 8'(SECTORS)));

    assert_take_then_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_take |=> (byte_vld && !byte_is_sync));

    assert_sync_only_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_is_sync |-> (byte_vld && byte_val == 8'hFF));

    assert_mark_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_is_sync && prev_sync) |-> (byte_val == 8'hD5 && run >= 8'(SYNC_MIN)));
endmodule

bind sector_stream_seq sss_checker #(
    .SYNC_MIN (SYNC_MIN),
    .SECTORS  (SECTORS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_is_sync (byte_is_sync),
    .sec_req      (sec_req),
    .sec_num      (sec_num),
    .pay_take     (pay_take)
);

// File: tb/tb_sector_stream_seq.sv
`timescale 1ns/1ps
module tb_sector_stream_seq;
    localparam int BC    = 4;
    localparam int SM    = 5;
    localparam int PB    = 16;
    localparam int HOLDB = 12;

    // entry = {kind[1:0], sector[3:0]}; kind 0 plain, 1 stalled gap, 2 busy during body
    localparam logic [5:0] VEC [0:13] = '{
        6'h00, 6'h06, 6'h11, 6'h07, 6'h22, 6'h08, 6'h03,
        6'h19, 6'h04, 6'h0A, 6'h25, 6'h0B, 6'h10, 6'h06
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] track;
    logic       side;
    logic       busy;
    logic [7:0] pay_data;
    logic       pay_take, sec_req, byte_vld, byte_is_sync;
    logic [7:0] sec_num, byte_val;

    int checks = 0;
    int fails  = 0;
    int pay_cnt = 0;

    always #4 clk = ~clk;

    assign pay_data = 8'(pay_cnt * 37 + 5);
    always @(posedge clk) if (pay_take) pay_cnt <= pay_cnt + 1;

    sector_stream_seq #(
        .SECTORS(12), .SYNC_MIN(SM), .PAY_BYTES(PB), .BYTE_CLKS(BC), .TRK_W(7), .INTERLEAVE(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .track(track), .side(side), .busy(busy),
        .pay_data(pay_data), .pay_take(pay_take), .sec_req(sec_req), .sec_num(sec_num),
        .byte_vld(byte_vld), .byte_val(byte_val), .byte_is_sync(byte_is_sync)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic get_byte(output logic [7:0] v, output logic s, output logic rq, output logic [7:0] sn);
        do @(negedge clk); while (!byte_vld);
        v  = byte_val;
        s  = byte_is_sync;
        rq = sec_req;
        sn = sec_num;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] v, sn;
        logic       s, rq;
        int         pidx, nsync, expn;
        pidx  = 0;
        track = 7'd17;
        side  = 1'b0;
        busy  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!byte_vld && !sec_req && !pay_take, "R1 outputs idle in reset",
            int'({byte_vld, sec_req, pay_take}), 0);
        rst_n = 1'b1;

        for (int e = 0; e < 14; e++) begin
            logic [1:0] kind;
            logic [3:0] esec;
            kind = VEC[e][5:4];
            esec = VEC[e][3:0];
            get_byte(v, s, rq, sn);
            chk(rq && s && sn == 8'(esec), "R3 R10 sector start (R1 on first)", int'(sn), int'(esec));
            if (kind == 2'd1) busy = 1'b1;
            nsync = 1;
            get_byte(v, s, rq, sn);
            while (s) begin
                nsync++;
                if (kind == 2'd1 && nsync == HOLDB + 1) busy = 1'b0;
                get_byte(v, s, rq, sn);
            end
            expn = (kind == 2'd1) ? HOLDB + 2 : SM;
            chk(nsync == expn, (kind == 2'd1) ? "R7 stretched gap" : "R4 sync run", nsync, expn);
            chk(v == 8'hD5 && !s, "R5 R11 mark 0", int'(v), 'hD5);
            if (kind == 2'd2) busy = 1'b1;
            get_byte(v, s, rq, sn);
            chk(v == 8'hAA && !s, "R5 mark 1", int'(v), 'hAA);
            get_byte(v, s, rq, sn);
            chk(v == 8'h96 && !s, "R5 mark 2", int'(v), 'h96);
            get_byte(v, s, rq, sn);
            chk(v == 8'd17 && !s, "R5 track byte", int'(v), 17);
            get_byte(v, s, rq, sn);
            chk(v == 8'(esec) && !s, "R5 sector byte", int'(v), int'(esec));
            get_byte(v, s, rq, sn);
            chk(v == 8'd0 && !s, "R5 side byte", int'(v), 0);
            for (int p = 0; p < PB; p++) begin
                get_byte(v, s, rq, sn);
                chk(!s && v == 8'(pidx * 37 + 5), (kind == 2'd2) ? "R8 payload under busy" : "R6 R11 payload",
                    int'(v), int'(8'(pidx * 37 + 5)));
                pidx++;
            end
            if (kind == 2'd2) busy = 1'b0;
        end

        // R2: strobe spacing
        begin
            int n;
            get_byte(v, s, rq, sn);
            n = 0;
            do begin @(negedge clk); n++; end while (!byte_vld);
            chk(n == BC, "R2 byte spacing", n, BC);
        end

        // R9: track change mid-gap
        do get_byte(v, s, rq, sn); while (!rq);
        get_byte(v, s, rq, sn);
        track = 7'd23;
        do get_byte(v, s, rq, sn); while (!rq);
        chk(sn == 8'd0, "R9 restart sector after track change", int'(sn), 0);
        do get_byte(v, s, rq, sn); while (s);
        chk(v == 8'hD5, "R9 mark after restart", int'(v), 'hD5);
        get_byte(v, s, rq, sn);
        get_byte(v, s, rq, sn);
        get_byte(v, s, rq, sn);
        chk(v == 8'd23, "R9 new track byte", int'(v), 23);

        // R9: side change; also R3 order resumes after restart
        do get_byte(v, s, rq, sn); while (!rq);
        chk(sn == 8'd6, "R3 second slot after restart", int'(sn), 6);
        get_byte(v, s, rq, sn);
        side = 1'b1;
        do get_byte(v, s, rq, sn); while (!rq);
        chk(sn == 8'd0, "R9 restart sector after side change", int'(sn), 0);
        do get_byte(v, s, rq, sn); while (s);
        for (int k = 0; k < 5; k++) get_byte(v, s, rq, sn);
        chk(v == 8'd1, "R9 new side byte", int'(v), 1);

        summary();
    end
endmodule